// File: doc/BRIEF.md
# Colour Lookup Table with Register Load Port

This block holds a 256-entry colour lookup table. Each entry has red, green and blue components of 8 bits. A host fills the table through a 16-byte register window with one write strobe. One register chooses an entry. The other takes colour bytes. Each colour byte comes from the top byte of a 32-bit bus word.

The host first writes a starting entry number. It then writes colour bytes one after another to the data register. An internal phase steps through red, green and blue. After blue, the entry number moves on by one, so a whole table can be streamed in after a single index write. A pixel path looks up an 8-bit index on a separate port and gets the 24-bit colour back one cycle later. Reads of the register window return zero.

Top module: `palette_dac`

## Requirements
- R1: A write at byte offset 0 loads the entry pointer from bits 31:24 of the write word. It also returns the colour phase to red, so the next data write lands in the red component of the new entry.
- R2: Each write at byte offset 4 stores bits 31:24 of the word into one component of the pointed entry. The component follows the phase: red, then green, then blue. Bits 23:0 of the word are discarded.
- R3: After the blue write, the pointer advances by one modulo 256 (255 wraps to 0) and the phase goes back to red.
- R4: The register read data output is always zero.
- R5: After reset, entries 0 to 254 are black (0x000000) and entry 255 is white (0xFFFFFF). The pointer and the phase are both zero, so a data write issued right after reset sets the red component of entry 0.
- R6: Writes at any other byte offset in the window (1, 2, 3 and 5 to 15) change neither the table, the pointer nor the phase.
- R7: The lookup output presents the entry selected by the lookup index one clock later, packed with red in bits 23:16, green in 15:8 and blue in 7:0. If a data write to that same entry happens in the same cycle as the lookup, the lookup returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_ofs | input | 4 | Byte offset of the write within the window |
| reg_wdata | input | 32 | Write data; the meaningful byte is 31:24 |
| reg_rdata | output | 32 | Register read data, always zero |
| pix_idx | input | 8 | Lookup index from the pixel path |
| pix_rgb | output | 24 | Looked-up colour, one cycle after pix_idx |

## Verification
The properties assume that reg_ofs holds a plain byte offset that is valid whenever reg_we is high. They also assume the strobe lasts one cycle per bus write, so each high cycle counts as exactly one register access. The stimulus drives every input on the falling edge. It raises reg_we for a single cycle per access and leaves reg_ofs and reg_wdata defined throughout. This covers every illegal offset once, the full pointer wrap from 255 back to 0, and a pointer reload issued partway through a colour triple.

// File: rtl/palette_dac.sv
module palette_dac #(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 8,
  parameter int BUS_W  = 32,
  parameter int OFS_W  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [OFS_W-1:0]    reg_ofs,
  input  logic [BUS_W-1:0]    reg_wdata,
  output logic [BUS_W-1:0]    reg_rdata,
  input  logic [IDX_W-1:0]    pix_idx,
  output logic [3*COMP_W-1:0] pix_rgb
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int RGB_W = 3 * COMP_W;
  localparam logic [OFS_W-1:0] OFS_PTR = OFS_W'(0);
  localparam logic [OFS_W-1:0] OFS_COL = OFS_W'(4);
  localparam logic [1:0] PH_RED = 2'd0;
  localparam logic [1:0] PH_GRN = 2'd1;

  logic [RGB_W-1:0]  lut [DEPTH];
  logic [IDX_W-1:0]  idx;
  logic [1:0]        phase;
  logic [COMP_W-1:0] byte_in;
  logic              sel_ptr, sel_col;

  assign reg_rdata = '0;
  assign byte_in   = reg_wdata[BUS_W-1 -: COMP_W];
  assign sel_ptr   = reg_we && (reg_ofs == OFS_PTR);
  assign sel_col   = reg_we && (reg_ofs == OFS_COL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx   <= '0;
      phase <= PH_RED;
    end else if (sel_ptr) begin
      idx   <= reg_wdata[BUS_W-1 -: IDX_W];
      phase <= PH_RED;
    end else if (sel_col) begin
      case (phase)
        PH_RED:  phase <= PH_GRN;
        PH_GRN:  phase <= 2'd2;
        default: begin
          phase <= PH_RED;
          idx   <= idx + IDX_W'(1);
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++)
        lut[i] <= (i == DEPTH - 1) ? {RGB_W{1'b1}} : {RGB_W{1'b0}};
    end else if (sel_col) begin
      case (phase)
        PH_RED:  lut[idx][3*COMP_W-1 -: COMP_W] <= byte_in;
        PH_GRN:  lut[idx][2*COMP_W-1 -: COMP_W] <= byte_in;
        default: lut[idx][COMP_W-1 -: COMP_W]   <= byte_in;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pix_rgb <= '0;
    else        pix_rgb <= lut[pix_idx];
  end
endmodule

// File: rtl/palette_dac_chk.sv
module palette_dac_chk #(
  parameter int IDX_W = 8,
  parameter int BUS_W = 32,
  parameter int OFS_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic [OFS_W-1:0] reg_ofs,
  input logic [BUS_W-1:0] reg_wdata,
  input logic [IDX_W-1:0] idx,
  input logic [1:0]       phase
);
  a_r1_ptr_load: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_ofs == OFS_W'(0)) |=>
      (idx == $past(reg_wdata[BUS_W-1 -: IDX_W]) && phase == 2'd0));

  a_r2_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_ofs == OFS_W'(4) && phase == 2'd0) |=>
      (phase == 2'd1 && $stable(idx)));

  a_r3_ptr_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_ofs == OFS_W'(4) && phase >= 2'd2) |=>
      (phase == 2'd0 && idx == $past(idx) + IDX_W'(1)));

  a_r6_ignored_ofs: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_ofs != OFS_W'(0) && reg_ofs != OFS_W'(4)) |=>
      ($stable(idx) && $stable(phase)));

  a_r3_phase_legal: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> (phase != 2'd3));
endmodule

bind palette_dac palette_dac_chk #(.IDX_W(IDX_W), .BUS_W(BUS_W), .OFS_W(OFS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_ofs(reg_ofs),
  .reg_wdata(reg_wdata), .idx(idx), .phase(phase)
);

// File: tb/tb_palette_dac.sv
module tb_palette_dac;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_we = 0;
  logic [3:0]  reg_ofs = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  pix_idx = '0;
  logic [23:0] pix_rgb;
  logic [23:0] exp_t [256];
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  palette_dac dut (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_ofs(reg_ofs),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pix_idx(pix_idx), .pix_rgb(pix_rgb));

  function automatic logic [7:0] f(int i, int c);
    return 8'((i * 7 + c * 85 + 3) & 255);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] ofs, logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_ofs = ofs; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic look(int i, string req);
    @(negedge clk); pix_idx = 8'(i);
    @(negedge clk); chk(req, {8'h0, pix_rgb}, {8'h0, exp_t[i]});
  endtask

  task automatic sweep(string req);
    for (int i = 0; i < 256; i++) look(i, req);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R4 / R5: reset contents and zero read data
    chk("R4", reg_rdata, 32'h0);
    for (int i = 0; i < 256; i++) exp_t[i] = (i == 255) ? 24'hFFFFFF : 24'h0;
    sweep("R5");
    // R5: pointer and phase start at zero
    wr(4'd4, 32'hA5123456); exp_t[0] = 24'hA50000;
    look(0, "R5");
    // R2 / R3: stream whole table from entry 0
    wr(4'd0, 32'h00FFFFFF);
    for (int i = 0; i < 256; i++)
      for (int c = 0; c < 3; c++) begin
        wr(4'd4, {f(i, c), 24'h5A5A5A});
        exp_t[i][23 - 8*c -: 8] = f(i, c);
      end
    sweep("R2");
    // R3: pointer wrapped from 255 to 0, phase back to red
    wr(4'd4, 32'h11000000); exp_t[0][23:16] = 8'h11;
    look(0, "R3");
    // R1: reload mid-triple restarts at red
    wr(4'd0, 32'h0A000000);
    wr(4'd4, 32'h22000000); exp_t[10][23:16] = 8'h22;
    wr(4'd4, 32'h33000000); exp_t[10][15:8]  = 8'h33;
    wr(4'd0, 32'h14000000);
    wr(4'd4, 32'h44000000); exp_t[20][23:16] = 8'h44;
    look(10, "R1"); look(20, "R1");
    chk("R4", reg_rdata, 32'h0);
    // R6: other offsets leave table, pointer and phase alone
    for (int o = 0; o < 16; o++)
      if (o != 0 && o != 4) wr(4'(o), {8'hFF, 20'h0, 4'(o)});
    sweep("R6");
    wr(4'd4, 32'h55000000); exp_t[20][15:8] = 8'h55;
    look(20, "R6");
    // R7: same-cycle write and lookup returns old value, new one a cycle later
    @(negedge clk);
    pix_idx = 8'd20; reg_we = 1; reg_ofs = 4'd4; reg_wdata = 32'h66000000;
    @(negedge clk);
    reg_we = 0;
    chk("R7", {8'h0, pix_rgb}, {8'h0, exp_t[20]});
    exp_t[20][7:0] = 8'h66;
    @(negedge clk);
    chk("R7", {8'h0, pix_rgb}, {8'h0, 24'h445566});
    // R3: pointer now at 21, red phase
    wr(4'd4, 32'h77000000); exp_t[21][23:16] = 8'h77;
    look(21, "R3");
    chk("R4", reg_rdata, 32'h0);
    summary();
  end
endmodule